// File: doc/BRIEF.md
# DMA Error Capture and Report Unit

This unit sits beside a DMA datapath and records the faults that datapath reports. Each fault arrives as a one-cycle event carrying its kind (read, write or address translation), the failing address, the 16-bit byte mask of the transfer and a flag marking a block transfer. The first fault seen while nothing is pending becomes the primary error. Its context is frozen in a 64-bit status word and a companion address register, and an interrupt is raised. Faults that arrive while a primary is pending only set sticky secondary flags, so the context always describes the first failure.

Software reads both registers over a small register port. It clears flags by writing ones to them in the status word; a zero leaves a flag as it was. A build parameter selects the correctable-error variant. That variant also stores an 8-bit check syndrome with the primary context and has no translation flags.

Top module: `dma_err_capture`

## Requirements
- R1: With no primary flag set, an accepted event sets the primary flag of its kind: read at status bit 62, write at bit 61, translation at bit 56. At most one primary flag is ever set.
- R2: An accepted event that arrives while any primary flag is set leaves the primary flags unchanged. It sets the secondary flag of its kind: read at bit 59, write at bit 58, translation at bit 57.
- R3: When a primary flag is set, the status word loads three fields from that event: its byte mask into bits 47:32, bits 5:3 of its address into bits 31:29, and its block flag into bit 23. The address register loads the event address, zero-extended to 64 bits. All of these hold while any primary flag is set.
- R4: A write to the status word (reg_sel = 0) clears every flag whose data bit is 1 and leaves flags with data bit 0 unchanged. Context fields and unused bits ignore writes.
- R5: If an event sets a flag in the same cycle that a write clears it, the flag ends up set.
- R6: irq is high exactly while at least one primary flag is set. Secondary flags alone keep it low.
- R7: In the correctable variant, the primary capture also stores the event syndrome in status bits 55:48, and translation events are ignored. In the default variant, bits 55:48 read as 0.
- R8: After reset, both registers read 0 and irq is low.
- R9: reg_rdata shows the status word when reg_sel = 0 and the address register when reg_sel = 1, in the same cycle. Writes with reg_sel = 1 have no effect. Events of kind 3 are ignored.
- R10: All register updates from an event or a write are visible on reg_rdata and irq in the cycle after the clock edge that samples them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Fault event strobe |
| ev_kind | input | 2 | Fault kind: 0 read, 1 write, 2 translation, 3 none |
| ev_addr | input | ADDR_W | Failing address |
| ev_bmask | input | 16 | Byte mask of the failing transfer |
| ev_block | input | 1 | Failing transfer was a block transfer |
| ev_synd | input | 8 | Check syndrome (used by the correctable variant only) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status word, 1 address register |
| reg_wdata | input | 64 | Write data (ones clear flags) |
| reg_rdata | output | 64 | Read data of the selected register |
| irq | output | 1 | Interrupt, high while any primary flag is set |

## Verification
The hardest state to reach is a collision between an event and a clear in one cycle. The event has to land on exactly the flag being cleared, and whether it becomes primary or secondary depends on a primary already being pending. Directed steps set up both cases on purpose. One clears the pending primary write flag together with the write secondary while a new write fault arrives. The other clears the read primary with nothing pending while a read fault arrives. A long seeded random run then mixes events, partial clears and address-register writes on both variants at once. This covers the many orderings of capture, freeze and release.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

    localparam int REG_W     = 64;

    localparam int P_RD_BIT  = 62;
    localparam int P_WR_BIT  = 61;
    localparam int P_XL_BIT  = 56;
    localparam int S_RD_BIT  = 59;
    localparam int S_WR_BIT  = 58;
    localparam int S_XL_BIT  = 57;

    localparam int BMASK_W   = 16;
    localparam int BMASK_LSB = 32;
    localparam int OFF_W     = 3;
    localparam int OFF_LSB   = 29;
    localparam int BLK_BIT   = 23;
    localparam int SYND_W    = 8;
    localparam int SYND_LSB  = 48;

    localparam logic [REG_W-1:0] FLAG_MASK =
        (64'd1 << P_RD_BIT) | (64'd1 << P_WR_BIT) | (64'd1 << P_XL_BIT) |
        (64'd1 << S_RD_BIT) | (64'd1 << S_WR_BIT) | (64'd1 << S_XL_BIT);

    typedef enum logic [1:0] {
        EK_READ  = 2'd0,
        EK_WRITE = 2'd1,
        EK_XLATE = 2'd2,
        EK_NONE  = 2'd3
    } err_kind_e;

    typedef struct packed {
        logic xl;
        logic wr;
        logic rd;
    } kind_vec_t;

endpackage

// File: rtl/errcap_flags.sv
module errcap_flags
    import errcap_pkg::*;
#(
    parameter bit XLATE_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ev_valid,
    input  err_kind_e ev_kind,
    input  kind_vec_t clr_prim,
    input  kind_vec_t clr_sec,
    output kind_vec_t prim_q,
    output kind_vec_t sec_q,
    output logic      prim_any,
    output logic      ctx_load
);

    typedef struct packed {
        kind_vec_t prim;
        kind_vec_t sec;
    } flag_st_t;

    flag_st_t  st_d, st_q;
    kind_vec_t hit_raw, hit, kind_ok;

    generate
        if (XLATE_EN) begin : g_xlate
            assign kind_ok = kind_vec_t'(3'b111);
        end else begin : g_no_xlate
            assign kind_ok = kind_vec_t'(3'b011);
        end
    endgenerate

    always_comb begin
        hit_raw = '0;
        if (ev_valid) begin
            case (ev_kind)
                EK_READ:  hit_raw.rd = 1'b1;
                EK_WRITE: hit_raw.wr = 1'b1;
                EK_XLATE: hit_raw.xl = 1'b1;
                default:  hit_raw    = '0;
            endcase
        end
    end

    assign hit      = hit_raw & kind_ok;
    assign prim_any = |st_q.prim;
    assign ctx_load = (|hit) && !prim_any;
    assign prim_q   = st_q.prim;
    assign sec_q    = st_q.sec;

    // Set beats clear: the clear mask is applied first, the event OR'ed after.
    always_comb begin
        st_d      = st_q;
        st_d.prim = (st_q.prim & ~clr_prim) | (prim_any ? kind_vec_t'('0) : hit);
        st_d.sec  = (st_q.sec  & ~clr_sec)  | (prim_any ? hit : kind_vec_t'('0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: never more than one primary flag
    a_r1_single_primary: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prim_q));

    // R2: a pending primary blocks any new primary flag
    a_r2_no_new_primary: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_any && ev_valid) |=> ((prim_q & ~$past(prim_q)) == 3'b000));

    // R4: a clear with no competing event removes the flag
    a_r4_clear_read: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_prim.rd && !(ev_valid && ev_kind == EK_READ)) |=> !prim_q.rd);

    // R5: an event on an idle unit wins over a same-cycle clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EK_READ && !prim_any) |=> prim_q.rd);

    generate
        if (!XLATE_EN) begin : g_chk_no_xlate
            // R7: translation flags stay clear in the correctable variant
            a_r7_no_xlate: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_valid && ev_kind == EK_XLATE) |=> !$rose(prim_q.xl) && !$rose(sec_q.xl));
        end
    endgenerate

endmodule

// File: rtl/errcap_context.sv
module errcap_context
    import errcap_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter bit SYND_EN = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctx_load,
    input  logic               prim_any,
    input  logic [ADDR_W-1:0]  ev_addr,
    input  logic [BMASK_W-1:0] ev_bmask,
    input  logic               ev_block,
    input  logic [SYND_W-1:0]  ev_synd,
    output logic [ADDR_W-1:0]  ctx_addr,
    output logic [BMASK_W-1:0] ctx_bmask,
    output logic               ctx_block,
    output logic [SYND_W-1:0]  ctx_synd
);

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [BMASK_W-1:0] bmask;
        logic               block;
        logic [SYND_W-1:0]  synd;
    } ctx_st_t;

    ctx_st_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (ctx_load) begin
            ctx_d.addr  = ev_addr;
            ctx_d.bmask = ev_bmask;
            ctx_d.block = ev_block;
            ctx_d.synd  = SYND_EN ? ev_synd : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign ctx_addr  = ctx_q.addr;
    assign ctx_bmask = ctx_q.bmask;
    assign ctx_block = ctx_q.block;
    assign ctx_synd  = ctx_q.synd;

    // R3: context frozen while a primary is pending
    a_r3_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        prim_any |=> $stable(ctx_q));

    // R3: capture takes the event's address
    a_r3_ctx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_load |=> (ctx_addr == $past(ev_addr)));

endmodule

// File: rtl/errcap_regif.sv
module errcap_regif
    import errcap_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    input  kind_vec_t          prim_q,
    input  kind_vec_t          sec_q,
    input  logic [ADDR_W-1:0]  ctx_addr,
    input  logic [BMASK_W-1:0] ctx_bmask,
    input  logic               ctx_block,
    input  logic [SYND_W-1:0]  ctx_synd,
    output logic [REG_W-1:0]   reg_rdata,
    output kind_vec_t          clr_prim,
    output kind_vec_t          clr_sec
);

    logic [REG_W-1:0] status_w, addr_w, clr_w;

    always_comb begin
        status_w                             = '0;
        status_w[P_RD_BIT]                   = prim_q.rd;
        status_w[P_WR_BIT]                   = prim_q.wr;
        status_w[P_XL_BIT]                   = prim_q.xl;
        status_w[S_RD_BIT]                   = sec_q.rd;
        status_w[S_WR_BIT]                   = sec_q.wr;
        status_w[S_XL_BIT]                   = sec_q.xl;
        status_w[SYND_LSB +: SYND_W]         = ctx_synd;
        status_w[BMASK_LSB +: BMASK_W]       = ctx_bmask;
        status_w[OFF_LSB +: OFF_W]           = ctx_addr[5:3];
        status_w[BLK_BIT]                    = ctx_block;
    end

    assign addr_w    = REG_W'(ctx_addr);
    assign reg_rdata = reg_sel ? addr_w : status_w;

    assign clr_w = (reg_wr && !reg_sel) ? (reg_wdata & FLAG_MASK) : '0;

    always_comb begin
        clr_prim.rd = clr_w[P_RD_BIT];
        clr_prim.wr = clr_w[P_WR_BIT];
        clr_prim.xl = clr_w[P_XL_BIT];
        clr_sec.rd  = clr_w[S_RD_BIT];
        clr_sec.wr  = clr_w[S_WR_BIT];
        clr_sec.xl  = clr_w[S_XL_BIT];
    end

    // R9: the address register never produces a clear
    always_comb begin
        if (reg_sel) begin
            a_r9_addr_no_clear: assert ((clr_prim == 3'b000) && (clr_sec == 3'b000));
        end
    end

endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
    import errcap_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter bit CORRECTABLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [15:0]       ev_bmask,
    input  logic              ev_block,
    input  logic [7:0]        ev_synd,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              irq
);

    localparam bit XLATE_EN = !CORRECTABLE;
    localparam bit SYND_EN  = CORRECTABLE;

    kind_vec_t          prim_q, sec_q, clr_prim, clr_sec;
    logic               prim_any, ctx_load;
    logic [ADDR_W-1:0]  ctx_addr;
    logic [BMASK_W-1:0] ctx_bmask;
    logic               ctx_block;
    logic [SYND_W-1:0]  ctx_synd;

    errcap_flags #(.XLATE_EN(XLATE_EN)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev_valid),
        .ev_kind  (err_kind_e'(ev_kind)),
        .clr_prim (clr_prim),
        .clr_sec  (clr_sec),
        .prim_q   (prim_q),
        .sec_q    (sec_q),
        .prim_any (prim_any),
        .ctx_load (ctx_load)
    );

    errcap_context #(.ADDR_W(ADDR_W), .SYND_EN(SYND_EN)) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctx_load  (ctx_load),
        .prim_any  (prim_any),
        .ev_addr   (ev_addr),
        .ev_bmask  (ev_bmask),
        .ev_block  (ev_block),
        .ev_synd   (ev_synd),
        .ctx_addr  (ctx_addr),
        .ctx_bmask (ctx_bmask),
        .ctx_block (ctx_block),
        .ctx_synd  (ctx_synd)
    );

    errcap_regif #(.ADDR_W(ADDR_W)) u_regif (
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .prim_q    (prim_q),
        .sec_q     (sec_q),
        .ctx_addr  (ctx_addr),
        .ctx_bmask (ctx_bmask),
        .ctx_block (ctx_block),
        .ctx_synd  (ctx_synd),
        .reg_rdata (reg_rdata),
        .clr_prim  (clr_prim),
        .clr_sec   (clr_sec)
    );

    assign irq = prim_any;

    // R6: the interrupt only rises after an event
    a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev_valid));

    // R6: a status write clearing every primary with no event drops irq
    a_r6_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata[P_RD_BIT] && reg_wdata[P_WR_BIT] &&
         reg_wdata[P_XL_BIT] && !ev_valid) |=> !irq);

endmodule

// File: tb/sim_dma_err_capture.sv
module sim_dma_err_capture;

    localparam int AW = 48;
    localparam logic [63:0] FMASK = (64'd1 << 62) | (64'd1 << 61) | (64'd1 << 56) |
                                    (64'd1 << 59) | (64'd1 << 58) | (64'd1 << 57);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic [1:0]    ev_kind = 2'd0;
    logic [AW-1:0] ev_addr = '0;
    logic [15:0]   ev_bmask = '0;
    logic          ev_block = 1'b0;
    logic [7:0]    ev_synd = '0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   rdata0, rdata1;
    logic          irq0, irq1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] m0s = '0, m0a = '0, m1s = '0, m1a = '0;

    always #10 clk = ~clk;

    dma_err_capture #(.ADDR_W(AW), .CORRECTABLE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_addr(ev_addr), .ev_bmask(ev_bmask), .ev_block(ev_block), .ev_synd(ev_synd),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(rdata0), .irq(irq0)
    );

    dma_err_capture #(.ADDR_W(AW), .CORRECTABLE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_addr(ev_addr), .ev_bmask(ev_bmask), .ev_block(ev_block), .ev_synd(ev_synd),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(rdata1), .irq(irq1)
    );

    // Expected next state from R1..R9, given current stimulus.
    function automatic void model_step(input bit corr, inout logic [63:0] st, inout logic [63:0] ad);
        logic [63:0] n;
        bit pend, ok;
        int pb, sb;
        n    = st;
        pend = st[62] | st[61] | st[56];
        if (reg_wr && !reg_sel) n = n & ~(reg_wdata & FMASK);
        ok = ev_valid && (ev_kind == 2'd0 || ev_kind == 2'd1 || (ev_kind == 2'd2 && !corr));
        pb = (ev_kind == 2'd0) ? 62 : (ev_kind == 2'd1) ? 61 : 56;
        sb = (ev_kind == 2'd0) ? 59 : (ev_kind == 2'd1) ? 58 : 57;
        if (ok) begin
            if (!pend) begin
                n[pb]    = 1'b1;
                n[47:32] = ev_bmask;
                n[31:29] = ev_addr[5:3];
                n[23]    = ev_block;
                n[55:48] = corr ? ev_synd : 8'h00;
                ad       = 64'(ev_addr);
            end else begin
                n[sb] = 1'b1;
            end
        end
        st = n;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        reg_sel = 1'b0;
        #1;
        chk({tag, " [status u0]"}, rdata0, m0s);
        chk({tag, " [status u1]"}, rdata1, m1s);
        reg_sel = 1'b1;
        #1;
        chk({tag, " [addr u0]"}, rdata0, m0a);
        chk({tag, " [addr u1]"}, rdata1, m1a);
        chk({tag, " [irq u0]"}, {63'd0, irq0}, {63'd0, m0s[62] | m0s[61] | m0s[56]});
        chk({tag, " [irq u1]"}, {63'd0, irq1}, {63'd0, m1s[62] | m1s[61] | m1s[56]});
        reg_sel = 1'b0;
    endtask

    task automatic set_ev(input logic [1:0] k, input logic [AW-1:0] a, input logic [15:0] bm,
                          input logic blk, input logic [7:0] sy);
        ev_valid = 1'b1; ev_kind = k; ev_addr = a; ev_bmask = bm; ev_block = blk; ev_synd = sy;
    endtask

    task automatic set_wr(input logic sel, input logic [63:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    endtask

    // R10: apply stimulus, expect its effect after the next rising edge.
    task automatic step(input string tag);
        model_step(1'b0, m0s, m0a);
        model_step(1'b1, m1s, m1a);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        reg_wr   = 1'b0;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E_0A77));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R8 reset state");

        set_ev(2'd0, 48'h0000_1234_56A8, 16'hF00F, 1'b1, 8'h5A);
        step("R1 R3 R7 first read fault captured");

        set_ev(2'd1, 48'h0000_0000_0F10, 16'h00FF, 1'b0, 8'h11);
        step("R2 R3 later write fault secondary, context frozen");

        set_ev(2'd2, 48'h0000_ABCD_0038, 16'h1111, 1'b1, 8'h22);
        step("R2 R7 translation fault secondary or ignored");

        set_wr(1'b0, 64'd0);
        step("R4 write of zeros changes nothing");

        set_wr(1'b0, ~FMASK);
        step("R4 context and unused bits ignore writes");

        set_wr(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R9 address register write ignored");

        set_ev(2'd3, 48'h0000_FFFF_FFF8, 16'hFFFF, 1'b1, 8'hFF);
        step("R9 kind 3 event ignored");

        set_wr(1'b0, 64'd1 << 62);
        step("R6 irq drops with only secondary flags");

        set_ev(2'd1, 48'h0000_7777_0018, 16'hA5A5, 1'b0, 8'h33);
        step("R1 R3 new primary after clear");

        set_ev(2'd1, 48'h0000_0101_0020, 16'h0F0F, 1'b1, 8'h44);
        set_wr(1'b0, (64'd1 << 61) | (64'd1 << 58));
        step("R5 event beats clear on secondary flag");

        set_ev(2'd0, 48'h0000_0202_0030, 16'hC3C3, 1'b1, 8'h55);
        set_wr(1'b0, 64'd1 << 62);
        step("R5 event beats clear on primary flag");

        set_wr(1'b0, FMASK);
        step("R4 clear every flag");

        for (int i = 0; i < 600; i++) begin
            if ($urandom % 2 == 0)
                set_ev(2'($urandom % 4), AW'({$urandom, $urandom}), 16'($urandom),
                       1'($urandom), 8'($urandom));
            if ($urandom % 5 == 0) begin
                if ($urandom % 3 == 0) set_wr(1'b0, FMASK);
                else set_wr(1'($urandom % 4 == 0), {$urandom, $urandom});
            end
            step("R1 R2 R3 R4 R5 R6 random mix");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule